// File: doc/BRIEF.md
# SerDes Lane Power-Up Sequencer

This block is a hardware state machine that takes one 6G SerDes lane from its reset condition to the state where transmit and receive data are enabled. It replaces a software bring-up routine. A single start pulse captures the requested lane format (quad or single SGMII), the line speed (1G or 2.5G), whether the reference clock runs at 125 MHz, and the transmit invert, receive invert and TX-to-RX loop requests.

From these inputs the block derives the word-width select, the TX and RX rate codes, the PLL multiplier and the reference divide-by-2 setting. It then raises the lane control outputs in a fixed order. Between stages it waits for a programmed number of milliseconds, counted in clock cycles. After each wait it checks one of the lane status inputs. Any failed check ends the run with an error code that identifies the stage. If every check passes, the run ends with done, and both data paths are enabled together.

Top module: `serdes_lane_seq`

## Requirements
- R1: After reset, busy_o, done_o and err_o are 0, every enable output is 0, and tx_rst_o, rx_rst_o and phy_rst_o are 1.
- R2: Two cycles after the start edge, the lane settings are driven and tx_rst_o and rx_rst_o are 0, one cycle before ref_en_o rises.
- R3: With mode_i=0 (QSGMII): sel10_o=0, both rate codes are 0, and speed_i has no effect. With ref125_i=1: mult_o=40 and ref_div2_o=1. With ref125_i=0: mult_o=100 and ref_div2_o=0.
- R4: With mode_i=1 (SGMII): sel10_o=1. With speed_i=1 (2.5G): both rate codes are 1 and mult_o is 50 (125 MHz reference) or 125 (other reference). With speed_i=0 (1G): both rate codes are 2 and mult_o is 40 or 100. ref_div2_o equals ref125_i.
- R5: ref_en_o rises three cycles after the start edge, and rx_term_o stays 0.
- R6: phy_rst_o falls CLKS_PER_MS cycles after ref_en_o rises, and pll_en_o rises CLKS_PER_MS cycles after that.
- R7: Seven milliseconds of cycles after pll_en_o rises, pll_st_i is sampled. Any value other than 1 ends the run with err_o=1, and cm_en_o stays 0.
- R8: If the PLL check passes, cm_en_o rises. One millisecond later cm_st_i must equal 1, otherwise the run ends with err_o=2.
- R9: If the common-mode check passes, rx_pll_en_o and tx_en_o rise in the same cycle. One millisecond later rx_pll_st_i must equal 1 (otherwise err_o=3), and then tx_st_i must equal 1 (otherwise err_o=4). When both checks fail, code 3 wins.
- R10: tx_data_en_o and rx_data_en_o rise together, in the same cycle as done_o, and only when all four checks pass.
- R11: busy_o is high from the cycle after an accepted start until done or error. A start pulse while busy_o is high is ignored, as are changes to the request inputs.
- R12: done_o and err_o hold until the next start. An accepted start returns every enable, reset and setting output to its reset value in the next cycle.
- R13: tx_inv_o and rx_inv_o equal the captured invert requests, and loop_o equals the captured loop request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| mode_i | input | 1 | 0 = QSGMII, 1 = SGMII |
| speed_i | input | 1 | 0 = 1G, 1 = 2.5G (SGMII only) |
| ref125_i | input | 1 | Reference clock is 125 MHz |
| tx_inv_req_i | input | 1 | Transmit polarity invert request |
| rx_inv_req_i | input | 1 | Receive polarity invert request |
| loop_req_i | input | 1 | TX-to-RX loop request |
| pll_st_i | input | STAT_W | PLL state status |
| cm_st_i | input | STAT_W | TX common-mode state status |
| rx_pll_st_i | input | STAT_W | RX PLL state status |
| tx_st_i | input | STAT_W | TX state status |
| sel10_o | output | 1 | 10-bit lane select |
| tx_rate_o | output | 2 | TX rate code |
| rx_rate_o | output | 2 | RX rate code |
| tx_inv_o | output | 1 | TX invert |
| rx_inv_o | output | 1 | RX invert |
| loop_o | output | 1 | Lane loopback enable |
| tx_rst_o | output | 1 | TX reset |
| rx_rst_o | output | 1 | RX reset |
| mult_o | output | 7 | PLL multiplier |
| ref_div2_o | output | 1 | Reference divide-by-2 |
| rx_term_o | output | 1 | Receive termination enable |
| ref_en_o | output | 1 | Reference clock enable |
| phy_rst_o | output | 1 | PHY reset |
| pll_en_o | output | 1 | PLL enable |
| cm_en_o | output | 1 | TX common-mode enable |
| rx_pll_en_o | output | 1 | RX PLL enable |
| tx_en_o | output | 1 | TX enable |
| tx_data_en_o | output | 1 | TX data enable |
| rx_data_en_o | output | 1 | RX data enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed |
| err_o | output | 3 | 0 none, 1 PLL, 2 common-mode, 3 RX PLL, 4 TX state |

## Verification
The bench sweeps all eight combinations of mode, speed and reference flag, and measures the spacing between every stage edge in cycles. A design with a wait off by one count, or with the 7 ms window swapped for a 1 ms one, therefore fails on timing. Each status check is failed in turn, including the status value 3: a design that tested only the low bit would accept 3 as good. The bench also fails the RX PLL and TX checks together, where a design with the wrong priority would report code 4. A start pulse sent mid-run with a different mode in place must leave both the timing and the multiplier unchanged. A restart must clear the enables left over from the previous run.

// File: rtl/lane_seq_pkg.sv
package lane_seq_pkg;
  localparam int MULT_W = 7;
  localparam int NUM_CHK = 4;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_PLL   = 3'd1,
    FLT_CM    = 3'd2,
    FLT_RXPLL = 3'd3,
    FLT_TX    = 3'd4
  } fault_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CFG, S_PLLCFG, S_W_REF, S_W_PHY, S_W_PLL, S_W_CM, S_W_LINK, S_DONE, S_FAIL
  } state_e;

  typedef struct packed {
    logic sgmii;
    logic fast;
    logic ref125;
    logic tx_inv;
    logic rx_inv;
    logic loop;
  } req_t;

  typedef struct packed {
    logic              sel10;
    logic [1:0]        tx_rate;
    logic [1:0]        rx_rate;
    logic [MULT_W-1:0] mult;
    logic              div2;
  } lane_set_t;
endpackage

// File: rtl/lane_param_calc.sv
module lane_param_calc
  import lane_seq_pkg::*;
(
  input  logic      sgmii_i,
  input  logic      fast_i,
  input  logic      ref125_i,
  output lane_set_t set_o
);
  logic [MULT_W-1:0] base_mult;
  logic [1:0]        rate;

  always_comb begin
    base_mult = ref125_i ? MULT_W'(40) : MULT_W'(100);
    rate      = 2'd0;
    set_o     = '0;
    if (sgmii_i) begin
      rate = fast_i ? 2'd1 : 2'd2;
      // 2.5G scales the PLL by 5/4
      if (fast_i) base_mult = ref125_i ? MULT_W'(50) : MULT_W'(125);
    end
    set_o.sel10   = sgmii_i;
    set_o.tx_rate = rate;
    set_o.rx_rate = rate;
    set_o.mult    = base_mult;
    set_o.div2    = ref125_i;
  end
endmodule

// File: rtl/lane_delay_timer.sv
module lane_delay_timer #(
  parameter int CLKS_PER_MS = 125000,
  parameter int MS_W        = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            expire_o
);
  localparam int MAX_CYC = CLKS_PER_MS * ((1 << MS_W) - 1);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load;
  logic             run_q;

  assign load     = CNT_W'(ms_i) * CNT_W'(CLKS_PER_MS) - CNT_W'(1);
  assign expire_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= load;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/lane_stat_cmp.sv
module lane_stat_cmp #(
  parameter int STAT_W = 2
) (
  input  logic [STAT_W-1:0] stat_i,
  output logic              pass_o
);
  assign pass_o = (stat_i == STAT_W'(1));
endmodule

// File: rtl/serdes_lane_seq.sv
module serdes_lane_seq
  import lane_seq_pkg::*;
#(
  parameter int CLKS_PER_MS = 125000,
  parameter int STAT_W      = 2,
  parameter int MS_W        = 4,
  parameter int REF_MS      = 1,
  parameter int PHY_MS      = 1,
  parameter int PLL_MS      = 7,
  parameter int CM_MS       = 1,
  parameter int LINK_MS     = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              speed_i,
  input  logic              ref125_i,
  input  logic              tx_inv_req_i,
  input  logic              rx_inv_req_i,
  input  logic              loop_req_i,
  input  logic [STAT_W-1:0] pll_st_i,
  input  logic [STAT_W-1:0] cm_st_i,
  input  logic [STAT_W-1:0] rx_pll_st_i,
  input  logic [STAT_W-1:0] tx_st_i,
  output logic              sel10_o,
  output logic [1:0]        tx_rate_o,
  output logic [1:0]        rx_rate_o,
  output logic              tx_inv_o,
  output logic              rx_inv_o,
  output logic              loop_o,
  output logic              tx_rst_o,
  output logic              rx_rst_o,
  output logic [6:0]        mult_o,
  output logic              ref_div2_o,
  output logic              rx_term_o,
  output logic              ref_en_o,
  output logic              phy_rst_o,
  output logic              pll_en_o,
  output logic              cm_en_o,
  output logic              rx_pll_en_o,
  output logic              tx_en_o,
  output logic              tx_data_en_o,
  output logic              rx_data_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        err_o
);
  localparam int CHK_PLL  = 0;
  localparam int CHK_CM   = 1;
  localparam int CHK_RXP  = 2;
  localparam int CHK_TX   = 3;

  state_e    state_q;
  req_t      req_q;
  req_t      req_d;
  lane_set_t set_c;
  lane_set_t set_q;
  fault_e    err_q;

  logic [STAT_W-1:0]  stat_vec [NUM_CHK];
  logic [NUM_CHK-1:0] pass;

  logic            tmr_start;
  logic [MS_W-1:0] tmr_ms;
  logic            tmr_exp;

  logic inv_tx_q, inv_rx_q, loop_q, tx_rst_q, rx_rst_q, rx_term_q;
  logic ref_en_q, phy_rst_q, pll_en_q, cm_en_q, rx_pll_en_q, tx_en_q, data_en_q, done_q;

  assign req_d = '{sgmii: mode_i, fast: speed_i, ref125: ref125_i,
                   tx_inv: tx_inv_req_i, rx_inv: rx_inv_req_i, loop: loop_req_i};

  lane_param_calc u_calc (
    .sgmii_i  (req_q.sgmii),
    .fast_i   (req_q.fast),
    .ref125_i (req_q.ref125),
    .set_o    (set_c)
  );

  lane_delay_timer #(.CLKS_PER_MS(CLKS_PER_MS), .MS_W(MS_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (tmr_start),
    .ms_i     (tmr_ms),
    .expire_o (tmr_exp)
  );

  assign stat_vec[CHK_PLL] = pll_st_i;
  assign stat_vec[CHK_CM]  = cm_st_i;
  assign stat_vec[CHK_RXP] = rx_pll_st_i;
  assign stat_vec[CHK_TX]  = tx_st_i;

  for (genvar g = 0; g < NUM_CHK; g++) begin : g_chk
    lane_stat_cmp #(.STAT_W(STAT_W)) u_cmp (
      .stat_i (stat_vec[g]),
      .pass_o (pass[g])
    );
  end

  // timer kicks at each stage entry
  always_comb begin
    tmr_start = 1'b0;
    tmr_ms    = '0;
    unique case (state_q)
      S_PLLCFG: begin tmr_start = 1'b1; tmr_ms = MS_W'(REF_MS); end
      S_W_REF:  begin tmr_start = tmr_exp; tmr_ms = MS_W'(PHY_MS); end
      S_W_PHY:  begin tmr_start = tmr_exp; tmr_ms = MS_W'(PLL_MS); end
      S_W_PLL:  begin tmr_start = tmr_exp && pass[CHK_PLL]; tmr_ms = MS_W'(CM_MS); end
      S_W_CM:   begin tmr_start = tmr_exp && pass[CHK_CM];  tmr_ms = MS_W'(LINK_MS); end
      default:  ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      req_q       <= '0;
      set_q       <= '0;
      err_q       <= FLT_NONE;
      inv_tx_q    <= 1'b0;
      inv_rx_q    <= 1'b0;
      loop_q      <= 1'b0;
      tx_rst_q    <= 1'b1;
      rx_rst_q    <= 1'b1;
      rx_term_q   <= 1'b0;
      ref_en_q    <= 1'b0;
      phy_rst_q   <= 1'b1;
      pll_en_q    <= 1'b0;
      cm_en_q     <= 1'b0;
      rx_pll_en_q <= 1'b0;
      tx_en_q     <= 1'b0;
      data_en_q   <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE, S_DONE, S_FAIL: begin
          if (start_i) begin
            req_q       <= req_d;
            set_q       <= '0;
            err_q       <= FLT_NONE;
            inv_tx_q    <= 1'b0;
            inv_rx_q    <= 1'b0;
            loop_q      <= 1'b0;
            tx_rst_q    <= 1'b1;
            rx_rst_q    <= 1'b1;
            rx_term_q   <= 1'b0;
            ref_en_q    <= 1'b0;
            phy_rst_q   <= 1'b1;
            pll_en_q    <= 1'b0;
            cm_en_q     <= 1'b0;
            rx_pll_en_q <= 1'b0;
            tx_en_q     <= 1'b0;
            data_en_q   <= 1'b0;
            done_q      <= 1'b0;
            state_q     <= S_CFG;
          end
        end
        S_CFG: begin
          set_q.sel10   <= set_c.sel10;
          set_q.tx_rate <= set_c.tx_rate;
          set_q.rx_rate <= set_c.rx_rate;
          inv_tx_q      <= req_q.tx_inv;
          inv_rx_q      <= req_q.rx_inv;
          loop_q        <= req_q.loop;
          tx_rst_q      <= 1'b0;
          rx_rst_q      <= 1'b0;
          state_q       <= S_PLLCFG;
        end
        S_PLLCFG: begin
          set_q.mult <= set_c.mult;
          set_q.div2 <= set_c.div2;
          rx_term_q  <= 1'b0;
          ref_en_q   <= 1'b1;
          state_q    <= S_W_REF;
        end
        S_W_REF: if (tmr_exp) begin
          phy_rst_q <= 1'b0;
          state_q   <= S_W_PHY;
        end
        S_W_PHY: if (tmr_exp) begin
          pll_en_q <= 1'b1;
          state_q  <= S_W_PLL;
        end
        S_W_PLL: if (tmr_exp) begin
          if (pass[CHK_PLL]) begin
            cm_en_q <= 1'b1;
            state_q <= S_W_CM;
          end else begin
            err_q   <= FLT_PLL;
            state_q <= S_FAIL;
          end
        end
        S_W_CM: if (tmr_exp) begin
          if (pass[CHK_CM]) begin
            rx_pll_en_q <= 1'b1;
            tx_en_q     <= 1'b1;
            state_q     <= S_W_LINK;
          end else begin
            err_q   <= FLT_CM;
            state_q <= S_FAIL;
          end
        end
        S_W_LINK: if (tmr_exp) begin
          if (!pass[CHK_RXP]) begin
            err_q   <= FLT_RXPLL;
            state_q <= S_FAIL;
          end else if (!pass[CHK_TX]) begin
            err_q   <= FLT_TX;
            state_q <= S_FAIL;
          end else begin
            data_en_q <= 1'b1;
            done_q    <= 1'b1;
            state_q   <= S_DONE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o       = !(state_q inside {S_IDLE, S_DONE, S_FAIL});
  assign sel10_o      = set_q.sel10;
  assign tx_rate_o    = set_q.tx_rate;
  assign rx_rate_o    = set_q.rx_rate;
  assign mult_o       = set_q.mult;
  assign ref_div2_o   = set_q.div2;
  assign tx_inv_o     = inv_tx_q;
  assign rx_inv_o     = inv_rx_q;
  assign loop_o       = loop_q;
  assign tx_rst_o     = tx_rst_q;
  assign rx_rst_o     = rx_rst_q;
  assign rx_term_o    = rx_term_q;
  assign ref_en_o     = ref_en_q;
  assign phy_rst_o    = phy_rst_q;
  assign pll_en_o     = pll_en_q;
  assign cm_en_o      = cm_en_q;
  assign rx_pll_en_o  = rx_pll_en_q;
  assign tx_en_o      = tx_en_q;
  assign tx_data_en_o = data_en_q;
  assign rx_data_en_o = data_en_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
endmodule

// File: rtl/lane_seq_chk.sv
module lane_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [2:0] err_o,
  input logic       tx_rst_o,
  input logic       rx_rst_o,
  input logic       rx_term_o,
  input logic       ref_en_o,
  input logic       phy_rst_o,
  input logic       pll_en_o,
  input logic       cm_en_o,
  input logic       rx_pll_en_o,
  input logic       tx_en_o,
  input logic       tx_data_en_o,
  input logic       rx_data_en_o
);
  // R2
  ref_after_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_en_o |-> (!tx_rst_o && !rx_rst_o));
  // R5
  term_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !rx_term_o);
  // R6
  pll_after_phy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_en_o |-> (!phy_rst_o && ref_en_o));
  // R8
  cm_after_pll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_en_o |-> pll_en_o);
  // R9
  link_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o == rx_pll_en_o) && (!tx_en_o || cm_en_o));
  // R10
  data_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_data_en_o || rx_data_en_o) |-> (tx_data_en_o && rx_data_en_o && tx_en_o && done_o));
  // R11
  busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!done_o && err_o == 3'd0));
  // R12
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  // R12
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o != 3'd0 && !start_i) |=> ($stable(err_o) && !busy_o));
endmodule

bind serdes_lane_seq lane_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .tx_rst_o     (tx_rst_o),
  .rx_rst_o     (rx_rst_o),
  .rx_term_o    (rx_term_o),
  .ref_en_o     (ref_en_o),
  .phy_rst_o    (phy_rst_o),
  .pll_en_o     (pll_en_o),
  .cm_en_o      (cm_en_o),
  .rx_pll_en_o  (rx_pll_en_o),
  .tx_en_o      (tx_en_o),
  .tx_data_en_o (tx_data_en_o),
  .rx_data_en_o (rx_data_en_o)
);

// File: tb/sim_serdes_lane_seq.sv
module sim_serdes_lane_seq;
  localparam int C = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0, speed = 1'b0, r125 = 1'b0, tinv = 1'b0, rinv = 1'b0, lpq = 1'b0;
  logic [1:0] pll_st = 2'd1, cm_st = 2'd1, rxp_st = 2'd1, tx_st = 2'd1;
  logic sel10, tx_inv, rx_inv, loop_en, tx_rst, rx_rst, div2, rx_term, ref_en, phy_rst;
  logic pll_en, cm_en, rxp_en, tx_en, txd_en, rxd_en, busy, done;
  logic [1:0] tx_rate, rx_rate;
  logic [6:0] mult;
  logic [2:0] err;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  serdes_lane_seq #(.CLKS_PER_MS(C)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .speed_i(speed),
    .ref125_i(r125), .tx_inv_req_i(tinv), .rx_inv_req_i(rinv), .loop_req_i(lpq),
    .pll_st_i(pll_st), .cm_st_i(cm_st), .rx_pll_st_i(rxp_st), .tx_st_i(tx_st),
    .sel10_o(sel10), .tx_rate_o(tx_rate), .rx_rate_o(rx_rate), .tx_inv_o(tx_inv),
    .rx_inv_o(rx_inv), .loop_o(loop_en), .tx_rst_o(tx_rst), .rx_rst_o(rx_rst),
    .mult_o(mult), .ref_div2_o(div2), .rx_term_o(rx_term), .ref_en_o(ref_en),
    .phy_rst_o(phy_rst), .pll_en_o(pll_en), .cm_en_o(cm_en), .rx_pll_en_o(rxp_en),
    .tx_en_o(tx_en), .tx_data_en_o(txd_en), .rx_data_en_o(rxd_en),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input bit m, input bit sp, input bit rf, input bit ti, input bit ri,
                     input bit lp, input int fsel, input logic [1:0] bad, input bit poke);
    int n = 1;
    int t_cfg = -1, t_ref = -1, t_phy = -1, t_pll = -1, t_cm = -1, t_rxp = -1, t_tx = -1, t_dat = -1, t_end = -1;
    int exp_err = (fsel == 5) ? 3 : fsel;
    int e_mult = rf ? 40 : 100;
    int e_rate = !m ? 0 : (sp ? 1 : 2);
    if (m && sp) e_mult = e_mult * 5 / 4;
    @(negedge clk);
    pll_st = (fsel == 1) ? bad : 2'd1;
    cm_st  = (fsel == 2) ? bad : 2'd1;
    rxp_st = (fsel == 3 || fsel == 5) ? bad : 2'd1;
    tx_st  = (fsel == 4 || fsel == 5) ? bad : 2'd1;
    mode = m; speed = sp; r125 = rf; tinv = ti; rinv = ri; lpq = lp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R11 R12: busy, everything back to reset values right after start
    chk(busy == 1'b1, "R11 busy after start", busy, 1);
    chk({done, err, pll_en, cm_en, tx_en, txd_en, ref_en} == '0 && tx_rst && phy_rst,
        "R12 outputs cleared on restart", {done, err, pll_en, txd_en}, 0);
    while (n < 400) begin
      if (poke && n == 6) begin start = 1'b1; mode = ~m; speed = ~sp; r125 = ~rf; end
      if (poke && n == 7) start = 1'b0;
      if (t_cfg < 0 && !tx_rst && !rx_rst) t_cfg = n;
      if (t_ref < 0 && ref_en) t_ref = n;
      if (t_phy < 0 && !phy_rst) t_phy = n;
      if (t_pll < 0 && pll_en) t_pll = n;
      if (t_cm < 0 && cm_en) t_cm = n;
      if (t_rxp < 0 && rxp_en) t_rxp = n;
      if (t_tx < 0 && tx_en) t_tx = n;
      if (t_dat < 0 && (txd_en || rxd_en)) t_dat = n;
      if (!busy) begin t_end = n; break; end
      @(negedge clk);
      n++;
    end
    chk(t_cfg == 2, "R2 config step cycle", t_cfg, 2);
    chk(t_ref == 3, "R5 ref enable cycle", t_ref, 3);
    chk(rx_term == 1'b0, "R5 termination off", rx_term, 0);
    chk(t_phy - t_ref == C, "R6 ref to phy reset release", t_phy - t_ref, C);
    chk(t_pll - t_phy == C, "R6 phy release to pll enable", t_pll - t_phy, C);
    chk(sel10 == m, m ? "R4 sel10" : "R3 sel10", sel10, m);
    chk(tx_rate == e_rate && rx_rate == e_rate, m ? "R4 rates" : "R3 rates", {tx_rate, rx_rate}, {e_rate[1:0], e_rate[1:0]});
    chk(mult == e_mult, m ? "R4 multiplier" : "R3 multiplier", mult, e_mult);
    chk(div2 == rf, m ? "R4 div2" : "R3 div2", div2, rf);
    chk(tx_inv == ti && rx_inv == ri && loop_en == lp, "R13 invert/loop", {tx_inv, rx_inv, loop_en}, {ti, ri, lp});
    chk(int'(err) == exp_err, "R7 R8 R9 error code", err, exp_err);
    case (exp_err)
      0: begin
        chk(t_cm - t_pll == 7 * C, "R7 pll wait", t_cm - t_pll, 7 * C);
        chk(t_tx - t_cm == C && t_rxp == t_tx, "R8 R9 cm wait, paired enables", t_tx - t_cm, C);
        chk(t_dat - t_tx == C, "R9 link wait", t_dat - t_tx, C);
        chk(t_end == t_dat && done && txd_en && rxd_en, "R10 data enables with done", {done, txd_en, rxd_en}, 7);
      end
      1: chk(t_end - t_pll == 7 * C && t_cm < 0 && !cm_en, "R7 pll fail", t_end - t_pll, 7 * C);
      2: chk(t_end - t_cm == C && t_tx < 0, "R8 cm fail", t_end - t_cm, C);
      default: chk(t_end - t_tx == C && t_dat < 0 && !done, "R9 R10 link fail", t_end - t_tx, C);
    endcase
    repeat (4) @(negedge clk);
    chk(!busy && done == (exp_err == 0) && int'(err) == exp_err, "R12 result held", {busy, done, err}, exp_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R11 watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk({busy, done, err, ref_en, pll_en, cm_en, rxp_en, tx_en, txd_en, rxd_en, rx_term} == '0,
        "R1 reset idle outputs", {busy, done, err}, 0);
    chk(tx_rst && rx_rst && phy_rst, "R1 resets asserted", {tx_rst, rx_rst, phy_rst}, 7);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++)
      run(i[0], i[1], i[2], i[0] ^ i[1], i[2], i[1] & ~i[0], 0, 2'd0, 1'b0);
    run(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1, 2'd0, 1'b0);
    run(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1, 2'd3, 1'b0);
    run(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2, 2'd2, 1'b0);
    run(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3, 2'd3, 1'b0);
    run(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4, 2'd0, 1'b0);
    run(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5, 2'd2, 1'b0);
    // R11: start and request changes during a run are ignored
    run(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0, 2'd0, 1'b1);
    run(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 0, 2'd0, 1'b1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule